// File: doc/BRIEF.md
# Bus-Mastering Pull Read Port

This block connects a processing unit that consumes tokens to a shared bus leading to a global FIFO memory. The processor first opens a connection and then asks for tokens one at a time with a pull request. Each request is served in a fixed order of phases. The port first waits until the global buffer reports that a token is present. It then requests the bus and waits for the grant. Once granted, it copies the word at its read pointer into a local holding register and gives the bus up. It pulses a room signal so that the buffer's free-space count goes up by one. Only after these steps does it present the token to the processor, together with a one-cycle acknowledge. The connection stays open until the processor closes it explicitly.

A pull request made while no connection is open is dropped and flagged for one cycle. The read pointer wraps at a parameterised buffer depth, which defaults to 8. Every output is driven from a register, so nothing passes combinationally from an input to an output.

Top module: `token_pull_unit`

## Requirements
- R1: `conn_open` sampled high while closed opens the connection from the next cycle, unless `conn_close` is also high. `conn_close` sampled high while open and idle closes it from the next cycle. A close that arrives while a transfer is in flight, or in the same cycle as an accepted `pull_req`, is ignored.
- R2: Each cycle in which `pull_req` is sampled high while the connection is closed makes `proto_err` high in the following cycle. Such a request starts no transfer. `proto_err` is low in every other cycle.
- R3: After a pull is accepted, `bus_req` stays low while `data_avail` is sampled low. `bus_req` rises in the cycle after `data_avail` is first sampled high.
- R4: `bus_req` stays high for any number of cycles until `bus_gnt` is sampled high. It then stays high for exactly one more cycle, the load cycle, and drops in the cycle after that.
- R5: During the load cycle, `rd_data` is captured into the local holding register.
- R6: `room_signal` is high for exactly one cycle per transfer, and that cycle is the one in which `bus_req` drops.
- R7: `pull_ack` is high for exactly one cycle, the cycle right after `room_signal`. In that cycle `pull_data` carries the captured token. In every other cycle `pull_data` is zero.
- R8: `rd_addr` is 0 after reset and advances by one, modulo DEPTH, at the end of each load cycle. The word read in the load cycle is the one at the pre-advance address.
- R9: A `pull_req` sampled while a transfer is in flight is ignored. It neither queues a second transfer nor raises `proto_err`.
- R10: While `rst` is high, and in the first cycle after it is released, every output is zero and the connection is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conn_open | input | 1 | Processor opens the connection |
| conn_close | input | 1 | Processor closes the connection |
| pull_req | input | 1 | Processor asks for one token |
| pull_ack | output | 1 | One-cycle completion pulse |
| pull_data | output | DW | Token to the processor, valid only with `pull_ack` |
| proto_err | output | 1 | Pull attempted on a closed connection |
| data_avail | input | 1 | Global buffer holds at least one token |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| rd_addr | output | $clog2(DEPTH) | Read pointer into the global buffer |
| rd_data | input | DW | Word returned by the global buffer |
| room_signal | output | 1 | One slot of room freed in the buffer |

## Verification
All outputs are registered, so every result appears a whole number of cycles after the edge that samples its cause. An accepted pull moves to the wait phase in the next cycle. `bus_req` appears one cycle after `data_avail` is sampled high, and the load cycle follows the first sampled grant by one cycle. `room_signal` comes one cycle after the load, and `pull_ack` one cycle after that. `proto_err` follows a rejected request by one cycle. The bench advances a behavioural model on each rising edge from the same sampled inputs. It compares every output with that model at the following falling edge, so each expected value is read in the exact cycle it is due, and the bus grant is returned after a latency that changes from run to run.

// File: rtl/pullrd_pkg.sv
package pullrd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WAIT  = 3'd1,
        PH_CLAIM = 3'd2,
        PH_LOAD  = 3'd3,
        PH_ROOM  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    typedef struct packed {
        logic own_bus;
        logic load;
        logic room;
        logic deliver;
    } step_s;

    function automatic step_s decode_phase(input phase_e ph);
        step_s s;
        s.own_bus = (ph == PH_CLAIM) || (ph == PH_LOAD);
        s.load    = (ph == PH_LOAD);
        s.room    = (ph == PH_ROOM);
        s.deliver = (ph == PH_DONE);
        return s;
    endfunction

    function automatic int unsigned wrap_inc(input int unsigned p,
                                             input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/pull_conn_track.sv
module pull_conn_track (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic close_i,
    input  logic pull_i,
    input  logic busy_i,
    output logic up_o,
    output logic start_o,
    output logic err_o
);

    logic up_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= pull_i & ~up_q;
            if (!up_q) begin
                up_q <= open_i & ~close_i;
            end else if (close_i && !busy_i && !pull_i) begin
                up_q <= 1'b0;
            end
        end
    end

    assign up_o    = up_q;
    assign start_o = up_q & pull_i & ~busy_i;
    assign err_o   = err_q;

    p_err_needs_pull_r2: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(pull_i));

    p_busy_keeps_conn_r1: assert property (@(posedge clk) disable iff (rst)
        (up_q && busy_i) |=> up_q);

endmodule

// File: rtl/pull_phase_fsm.sv
module pull_phase_fsm
    import pullrd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   avail_i,
    input  logic   gnt_i,
    output phase_e ph_o,
    output logic   busy_o
);

    phase_e ph_q;
    phase_e ph_d;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (start_i) ph_d = PH_WAIT;
            PH_WAIT:  if (avail_i) ph_d = PH_CLAIM;
            PH_CLAIM: if (gnt_i)   ph_d = PH_LOAD;
            PH_LOAD:  ph_d = PH_ROOM;
            PH_ROOM:  ph_d = PH_DONE;
            PH_DONE:  ph_d = PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign ph_o   = ph_q;
    assign busy_o = (ph_q != PH_IDLE);

    p_wait_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WAIT && !avail_i) |=> ph_q == PH_WAIT);

    p_claim_waits_r4: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_CLAIM && !gnt_i) |=> ph_q == PH_CLAIM);

endmodule

// File: rtl/token_hold_reg.sv
module token_hold_reg
    import pullrd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          deliver_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);

    logic [AW-1:0] ptr_q;
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            hold_q <= '0;
        end else if (load_i) begin
            hold_q <= rd_data_i;
            ptr_q  <= AW'(wrap_inc(int'(ptr_q), DEPTH));
        end
    end

    assign addr_o = ptr_q;
    assign data_o = deliver_i ? hold_q : '0;

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !$past(load_i)) |-> $stable(hold_q));

endmodule

// File: rtl/token_pull_unit.sv
module token_pull_unit
    import pullrd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conn_open,
    input  logic          conn_close,
    input  logic          pull_req,
    output logic          pull_ack,
    output logic [DW-1:0] pull_data,
    output logic          proto_err,
    input  logic          data_avail,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          room_signal
);

    logic   conn_up;
    logic   start;
    logic   busy;
    phase_e phase;
    step_s  step;

    pull_conn_track u_conn (
        .clk     (clk),
        .rst     (rst),
        .open_i  (conn_open),
        .close_i (conn_close),
        .pull_i  (pull_req),
        .busy_i  (busy),
        .up_o    (conn_up),
        .start_o (start),
        .err_o   (proto_err)
    );

    pull_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .avail_i (data_avail),
        .gnt_i   (bus_gnt),
        .ph_o    (phase),
        .busy_o  (busy)
    );

    assign step = decode_phase(phase);

    token_hold_reg #(.DW(DW), .DEPTH(DEPTH)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load_i    (step.load),
        .deliver_i (step.deliver),
        .rd_data_i (rd_data),
        .addr_o    (rd_addr),
        .data_o    (pull_data)
    );

    assign bus_req     = step.own_bus;
    assign room_signal = step.room;
    assign pull_ack    = step.deliver;

    p_req_after_data_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(data_avail));

    p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |=> bus_req);

    p_release_after_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> $past(bus_gnt, 2));

    p_release_with_room_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> room_signal);

    p_room_single_r6: assert property (@(posedge clk) disable iff (rst)
        room_signal |=> !room_signal);

    p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
        pull_ack |=> !pull_ack);

    p_ack_after_room_r7: assert property (@(posedge clk) disable iff (rst)
        pull_ack |-> $past(room_signal));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        room_signal |-> rd_addr == AW'(wrap_inc(int'($past(rd_addr)), DEPTH)));

    p_no_req_when_closed_r2: assert property (@(posedge clk) disable iff (rst)
        (!conn_up && !busy) |-> !bus_req);

endmodule

// File: tb/token_pull_unit_test.sv
module token_pull_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int AW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conn_open = 1'b0;
    logic          conn_close = 1'b0;
    logic          pull_req = 1'b0;
    logic          data_avail = 1'b0;
    logic          bus_gnt = 1'b0;
    logic          pull_ack;
    logic [DW-1:0] pull_data;
    logic          proto_err;
    logic          bus_req;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          room_signal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int salt   = 5;
    int gnt_lat = 0;
    int wcnt   = 0;
    int acks   = 0;

    // behavioural model state
    bit            m_conn = 0;
    int            m_ph   = 0;
    int            m_ptr  = 0;
    logic [DW-1:0] m_hold = '0;
    bit            m_err  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] tok(input int a);
        return DW'(a * 37 + salt * 11);
    endfunction

    assign rd_data = tok(int'(rd_addr));

    token_pull_unit #(.DW(DW), .DEPTH(DEPTH)) uut (
        .clk         (clk),
        .rst         (rst),
        .conn_open   (conn_open),
        .conn_close  (conn_close),
        .pull_req    (pull_req),
        .pull_ack    (pull_ack),
        .pull_data   (pull_data),
        .proto_err   (proto_err),
        .data_avail  (data_avail),
        .bus_req     (bus_req),
        .bus_gnt     (bus_gnt),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .room_signal (room_signal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // reference model: advances on the same sampled inputs as the design
    always @(posedge clk) begin
        if (rst) begin
            m_conn = 0; m_ph = 0; m_ptr = 0; m_hold = '0; m_err = 0;
        end else begin
            bit busy, start, n_err;
            busy  = (m_ph != 0);
            n_err = pull_req && !m_conn;
            start = m_conn && pull_req && !busy;
            if (!m_conn) begin
                if (conn_open && !conn_close) m_conn = 1;
            end else if (conn_close && !busy && !pull_req) begin
                m_conn = 0;
            end
            case (m_ph)
                0: if (start) m_ph = 1;
                1: if (data_avail) m_ph = 2;
                2: if (bus_gnt) m_ph = 3;
                3: begin m_hold = tok(m_ptr); m_ptr = (m_ptr + 1) % DEPTH; m_ph = 4; end
                4: m_ph = 5;
                default: m_ph = 0;
            endcase
            m_err = n_err;
        end
    end

    // arbiter stand-in with a programmable grant latency
    always @(negedge clk) begin
        if (!bus_req) begin
            wcnt = 0;
            bus_gnt = 1'b0;
        end else begin
            bus_gnt = (wcnt >= gnt_lat);
            wcnt++;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 R3 R4 R9 bus_req", 32'(bus_req), 32'(m_ph == 2 || m_ph == 3));
            chk("R6 room_signal", 32'(room_signal), 32'(m_ph == 4));
            chk("R7 pull_ack", 32'(pull_ack), 32'(m_ph == 5));
            chk("R5 R7 pull_data", 32'(pull_data), (m_ph == 5) ? 32'(m_hold) : 32'd0);
            chk("R2 proto_err", 32'(proto_err), 32'(m_err));
            chk("R8 rd_addr", 32'(rd_addr), 32'(m_ptr));
            if (pull_ack) acks++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pull();
        pull_req = 1'b1; cyc(1); pull_req = 1'b0;
    endtask

    task automatic settle();
        cyc(1);
        for (int i = 0; i < 60 && m_ph != 0; i++) cyc(1);
        cyc(1);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R7 watchdog: transfer never completed, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int a0;
        cyc(3);
        // R10: outputs idle during reset
        chk("R10 reset outputs", {pull_ack, proto_err, bus_req, room_signal, 12'd0}, 16'd0);
        chk("R10 reset data/addr", {16'(pull_data), 13'd0, rd_addr}, 32'd0);
        rst = 1'b0;
        cyc(1);
        chk("R10 after release", {pull_ack, proto_err, bus_req, room_signal}, 4'd0);

        // R2: pull on a closed connection is rejected and flagged
        data_avail = 1'b1;
        pulse_pull();
        chk("R2 error flag", 32'(proto_err), 32'd1);
        cyc(1);
        chk("R2 error pulse ends", 32'(proto_err), 32'd0);
        chk("R2 no bus request", 32'(bus_req), 32'd0);

        // R1: open together with pull still rejects that pull
        conn_open = 1'b1; pull_req = 1'b1; cyc(1);
        conn_open = 1'b0; pull_req = 1'b0;
        chk("R1 R2 pull before open", 32'(proto_err), 32'd1);
        cyc(2);

        // R3: blocked on empty buffer, no bus request
        data_avail = 1'b0;
        pulse_pull();
        cyc(5);
        chk("R3 no request while empty", 32'(bus_req), 32'd0);
        data_avail = 1'b1;
        cyc(1);
        chk("R3 request after data", 32'(bus_req), 32'd1);
        settle();

        // R4: long grant latency
        gnt_lat = 6;
        pulse_pull();
        cyc(5);
        chk("R4 request held awaiting grant", 32'(bus_req), 32'd1);
        settle();

        // R9: pull held high through a transfer
        gnt_lat = 2;
        a0 = acks;
        pull_req = 1'b1; cyc(9); pull_req = 1'b0;
        settle();
        chk("R9 one transfer per held pull window", 32'(acks - a0), 32'd2);

        // R1: close during a transfer is ignored
        pulse_pull();
        conn_close = 1'b1; cyc(1); conn_close = 1'b0;
        settle();
        pulse_pull();
        cyc(1);
        chk("R1 close in flight ignored", 32'(proto_err), 32'd0);
        settle();

        // R1: close while idle takes effect
        conn_close = 1'b1; cyc(1); conn_close = 1'b0;
        pulse_pull();
        chk("R1 R2 closed after close", 32'(proto_err), 32'd1);
        cyc(1);
        conn_open = 1'b1; cyc(1); conn_open = 1'b0;

        // R8: wrap of the read pointer with varying latency and data
        for (int k = 0; k < 11; k++) begin
            gnt_lat = k % 4;
            salt = salt + 3;
            pulse_pull();
            settle();
        end
        chk("R8 transfers completed", 32'(acks), 32'd17);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule